// File: doc/BRIEF.md
# MSI Snooping Coherence Controller

This block keeps a small direct-mapped cache coherent on a shared, totally ordered snooping bus. It uses a three-state write-back invalidation scheme. Each line holds a tag, one data word and a state: Invalid, Shared or Modified. Modified means this cache holds the only copy, that copy is dirty, and memory is stale. The processor side sends loads, stores and explicit evictions. Hits finish locally. Misses, write permission requests and dirty write-backs become bus transactions, issued one at a time. The processor is held until the transaction finishes.

The bus side watches the transactions of other agents in bus order. It demotes or invalidates matching lines. When this cache owns a line that another agent needs, it supplies the data. Arbitration is external: the block raises a request, keeps its command on the bus outputs, and treats the grant cycle as the ordering point of its own transaction. Fill data for reads and read-for-ownership comes back later on a fill input, from memory or from another cache.

A store to a Shared line asks for write permission. It uses an address-only Upgrade when the `UPGR_EN` parameter is set, and a full GETX otherwise. A miss that lands on a line holding a different dirty tag first writes the victim back with PUTX, then issues its own request.

Top module: `msi_snoop_ctrl`

## Requirements
- R1: After reset, every line is Invalid and the outputs `cpu_stall`, `cpu_done`, `bus_req` and `snp_supply` are 0. Operation codes are load=0, store=1, evict=2. Bus command codes are GETS=0, GETX=1, Upgrade=2, PUTX=3. The line index is the low `log2(NLINES)` address bits and the tag is the remaining upper bits.
- R2: A load that misses raises `bus_req` with GETS at the load address. After the grant and then the fill, `cpu_done` pulses with the fill data and the line is Shared. A later load to that address completes one cycle after acceptance without a bus request.
- R3: A store that misses issues GETX and ignores the fill data. The line becomes Modified and holds the store data. A store that hits a Modified line completes locally in one cycle without a bus request.
- R4: With `UPGR_EN`=1, a store that hits a Shared line issues Upgrade at the store address and needs no fill. `cpu_done` pulses one cycle after the grant, and the line becomes Modified with the store data.
- R5: When another agent's GETS hits a Modified line, `snp_supply` pulses one cycle later with the line data on `snp_data`, and the line becomes Shared.
- R6: When another agent's GETX hits a valid line, the line becomes Invalid. `snp_supply` pulses with the data only if the line was Modified.
- R7: A snooped transaction whose tag differs from the stored tag, that targets an Invalid line, or that is a PUTX, has no effect on any line and does not assert `snp_supply`.
- R8: Evicting a Modified line issues PUTX with the line's address and data, and the line is Invalid once granted. Evicting a Shared line completes in one cycle with no bus request and leaves the line Invalid. Evicting an address that is not present completes in one cycle with no bus request.
- R9: If another agent's GETX invalidates the line of a waiting Upgrade before it is granted, the pending command becomes GETX and then completes through a fill.
- R10: A miss onto a line that holds a different tag in Modified first issues PUTX for the victim, then the demand request.
- R11: If a snoop takes away the line of a waiting eviction, no PUTX is issued and the eviction completes on the next cycle.
- R12: `cpu_stall` is 1 from the cycle after a request that needs the bus is accepted until the cycle in which `cpu_done` pulses. `bus_req` is only ever 1 while `cpu_stall` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cpu_req_valid | input | 1 | Processor request strobe, taken when not stalled |
| cpu_req_op | input | 2 | Operation: load, store or evict |
| cpu_req_addr | input | AW | Request address |
| cpu_req_wdata | input | DW | Store data |
| cpu_stall | output | 1 | Request outstanding on the bus |
| cpu_done | output | 1 | One-cycle completion pulse |
| cpu_rdata | output | DW | Load result, or store data for stores |
| bus_req | output | 1 | Request to the bus arbiter |
| bus_gnt | input | 1 | Grant; the ordering point of the own transaction |
| bus_cmd | output | 2 | Own bus command |
| bus_addr | output | AW | Own bus address |
| bus_wdata | output | DW | Write-back data for PUTX |
| bus_fill_valid | input | 1 | Fill data for a granted GETS or GETX |
| bus_fill_data | input | DW | Fill data word |
| snp_valid | input | 1 | Another agent's transaction on the bus |
| snp_cmd | input | 2 | Snooped command |
| snp_addr | input | AW | Snooped address |
| snp_supply | output | 1 | This cache supplies the data as owner |
| snp_data | output | DW | Supplied data word |

## Verification
Bus command, address and request are combinational from registered state. They become valid in the cycle after a request is accepted, and again in the cycle after each grant or snoop that changes them. `cpu_done` arrives one cycle after the edge that accepts a hit, grants an Upgrade or PUTX eviction, or delivers a fill. `snp_supply` arrives one cycle after the snoop. The bench changes inputs and samples outputs only at falling edges, so each check reads the value produced by the rising edge just before it. Line state is not read directly: the bench infers it from which bus command the next access issues, or from whether that access completes locally.

// File: rtl/msi_pkg.sv
package msi_pkg;

    typedef enum logic [1:0] {
        LN_I = 2'd0,
        LN_S = 2'd1,
        LN_M = 2'd2
    } line_st_e;

    typedef enum logic [1:0] {
        OP_LOAD  = 2'd0,
        OP_STORE = 2'd1,
        OP_EVICT = 2'd2
    } cpu_op_e;

    typedef enum logic [1:0] {
        BC_GETS = 2'd0,
        BC_GETX = 2'd1,
        BC_UPGR = 2'd2,
        BC_PUTX = 2'd3
    } bus_cmd_e;

    typedef enum logic [1:0] {
        RQ_IDLE      = 2'd0,
        RQ_WAIT_GNT  = 2'd1,
        RQ_WAIT_FILL = 2'd2
    } rq_fsm_e;

    typedef struct packed {
        logic     need_bus;
        logic     victim;
        bus_cmd_e cmd;
    } plan_t;

    // Decide what an access needs, given the current state of its line.
    function automatic plan_t plan_access(input cpu_op_e op, input line_st_e st,
                                          input logic tag_hit, input logic upg_en);
        plan_t p;
        p.need_bus = 1'b0;
        p.victim   = 1'b0;
        p.cmd      = BC_GETS;
        case (op)
            OP_LOAD: begin
                if (!tag_hit) begin
                    p.need_bus = 1'b1;
                    if (st == LN_M) begin
                        p.victim = 1'b1;
                        p.cmd    = BC_PUTX;
                    end else begin
                        p.cmd = BC_GETS;
                    end
                end
            end
            OP_STORE: begin
                if (tag_hit && st == LN_S) begin
                    p.need_bus = 1'b1;
                    p.cmd      = upg_en ? BC_UPGR : BC_GETX;
                end else if (!tag_hit) begin
                    p.need_bus = 1'b1;
                    if (st == LN_M) begin
                        p.victim = 1'b1;
                        p.cmd    = BC_PUTX;
                    end else begin
                        p.cmd = BC_GETX;
                    end
                end
            end
            OP_EVICT: begin
                if (tag_hit && st == LN_M) begin
                    p.need_bus = 1'b1;
                    p.cmd      = BC_PUTX;
                end
            end
            default: p.need_bus = 1'b0;
        endcase
        return p;
    endfunction

endpackage

// File: rtl/msi_line_store.sv
module msi_line_store
    import msi_pkg::*;
#(
    parameter int NLINES = 4,
    parameter int TW     = 6,
    parameter int DW     = 16,
    localparam int IW    = $clog2(NLINES)
) (
    input  logic                         clk,
    input  logic                         rst_n,
    // processor-side write port
    input  logic [IW-1:0]                wr_idx,
    input  logic                         wr_st_en,
    input  logic [1:0]                   wr_st,
    input  logic                         wr_tag_en,
    input  logic [TW-1:0]                wr_tag,
    input  logic                         wr_data_en,
    input  logic [DW-1:0]                wr_data,
    // snoop-side state port, wins over the processor port
    input  logic                         sn_en,
    input  logic [IW-1:0]                sn_idx,
    input  logic [1:0]                   sn_st,
    output logic [NLINES-1:0][1:0]       st_o,
    output logic [NLINES-1:0][TW-1:0]    tag_o,
    output logic [NLINES-1:0][DW-1:0]    data_o
);

    typedef struct packed {
        logic [1:0]    st;
        logic [TW-1:0] tag;
        logic [DW-1:0] data;
    } line_t;

    for (genvar g = 0; g < NLINES; g++) begin : g_line
        line_t line_d, line_q;

        always_comb begin
            line_d = line_q;
            if (wr_idx == IW'(g)) begin
                if (wr_st_en)   line_d.st   = wr_st;
                if (wr_tag_en)  line_d.tag  = wr_tag;
                if (wr_data_en) line_d.data = wr_data;
            end
            if (sn_en && sn_idx == IW'(g)) line_d.st = sn_st;
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                line_q <= '{st: LN_I, tag: '0, data: '0};
            end else begin
                line_q <= line_d;
            end
        end

        assign st_o[g]   = line_q.st;
        assign tag_o[g]  = line_q.tag;
        assign data_o[g] = line_q.data;
    end

endmodule

// File: rtl/msi_snoop_unit.sv
module msi_snoop_unit
    import msi_pkg::*;
#(
    parameter int AW     = 8,
    parameter int NLINES = 4,
    parameter int DW     = 16,
    localparam int IW    = $clog2(NLINES),
    localparam int TW    = AW - IW
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      snp_valid,
    input  logic [1:0]                snp_cmd,
    input  logic [AW-1:0]             snp_addr,
    input  logic [NLINES-1:0][1:0]    st_i,
    input  logic [NLINES-1:0][TW-1:0] tag_i,
    input  logic [NLINES-1:0][DW-1:0] data_i,
    output logic                      upd_en,
    output logic [IW-1:0]             upd_idx,
    output logic [1:0]                upd_st,
    output logic                      snp_supply,
    output logic [DW-1:0]             snp_data
);

    typedef struct packed {
        logic          supply;
        logic [DW-1:0] data;
    } resp_t;

    resp_t resp_d, resp_q;

    logic [TW-1:0] sn_tag;
    line_st_e      sn_cur;
    logic          sn_hit;
    logic          give;

    always_comb begin
        upd_idx = snp_addr[IW-1:0];
        sn_tag  = snp_addr[AW-1:IW];
        sn_cur  = line_st_e'(st_i[upd_idx]);
        sn_hit  = snp_valid && sn_cur != LN_I && tag_i[upd_idx] == sn_tag;
        upd_en  = 1'b0;
        upd_st  = sn_cur;
        give    = 1'b0;
        if (sn_hit) begin
            case (bus_cmd_e'(snp_cmd))
                BC_GETS: begin
                    if (sn_cur == LN_M) begin
                        upd_en = 1'b1;
                        upd_st = LN_S;
                        give   = 1'b1;
                    end
                end
                BC_GETX, BC_UPGR: begin
                    upd_en = 1'b1;
                    upd_st = LN_I;
                    give   = (sn_cur == LN_M);
                end
                default: upd_en = 1'b0;
            endcase
        end
        resp_d.supply = give;
        resp_d.data   = give ? data_i[upd_idx] : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            resp_q <= '0;
        end else begin
            resp_q <= resp_d;
        end
    end

    assign snp_supply = resp_q.supply;
    assign snp_data   = resp_q.data;

endmodule

// File: rtl/msi_req_ctrl.sv
module msi_req_ctrl
    import msi_pkg::*;
#(
    parameter int AW      = 8,
    parameter int NLINES  = 4,
    parameter int DW      = 16,
    parameter bit UPGR_EN = 1'b1,
    localparam int IW     = $clog2(NLINES),
    localparam int TW     = AW - IW
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      cpu_req_valid,
    input  logic [1:0]                cpu_req_op,
    input  logic [AW-1:0]             cpu_req_addr,
    input  logic [DW-1:0]             cpu_req_wdata,
    output logic                      cpu_stall,
    output logic                      cpu_done,
    output logic [DW-1:0]             cpu_rdata,
    output logic                      bus_req,
    output logic [1:0]                bus_cmd,
    output logic [AW-1:0]             bus_addr,
    output logic [DW-1:0]             bus_wdata,
    input  logic                      bus_gnt,
    input  logic                      bus_fill_valid,
    input  logic [DW-1:0]             bus_fill_data,
    input  logic [NLINES-1:0][1:0]    st_i,
    input  logic [NLINES-1:0][TW-1:0] tag_i,
    input  logic [NLINES-1:0][DW-1:0] data_i,
    output logic [IW-1:0]             wr_idx,
    output logic                      wr_st_en,
    output logic [1:0]                wr_st,
    output logic                      wr_tag_en,
    output logic [TW-1:0]             wr_tag,
    output logic                      wr_data_en,
    output logic [DW-1:0]             wr_data
);

    typedef struct packed {
        rq_fsm_e       fsm;
        logic [1:0]    op;
        logic [AW-1:0] addr;
        logic [DW-1:0] wdata;
        logic          done;
        logic [DW-1:0] rdata;
    } rq_t;

    rq_t rq_d, rq_q;

    logic [1:0]    sel_op;
    logic [AW-1:0] sel_addr;
    logic [DW-1:0] sel_wdata;
    logic [TW-1:0] acc_tag;
    line_st_e      cur_st;
    logic [DW-1:0] cur_data;
    logic          tag_hit;
    plan_t         plan;
    logic          local_done;

    // decode of the access currently presented or pending
    always_comb begin
        sel_op    = (rq_q.fsm == RQ_IDLE) ? cpu_req_op    : rq_q.op;
        sel_addr  = (rq_q.fsm == RQ_IDLE) ? cpu_req_addr  : rq_q.addr;
        sel_wdata = (rq_q.fsm == RQ_IDLE) ? cpu_req_wdata : rq_q.wdata;
        wr_idx    = sel_addr[IW-1:0];
        acc_tag   = sel_addr[AW-1:IW];
        cur_st    = line_st_e'(st_i[wr_idx]);
        cur_data  = data_i[wr_idx];
        tag_hit   = cur_st != LN_I && tag_i[wr_idx] == acc_tag;
        plan      = plan_access(cpu_op_e'(sel_op), cur_st, tag_hit, UPGR_EN);
        local_done = !plan.need_bus &&
                     ((rq_q.fsm == RQ_IDLE && cpu_req_valid) || rq_q.fsm == RQ_WAIT_GNT);
    end

    // next state and line writes
    always_comb begin
        rq_d       = rq_q;
        rq_d.done  = 1'b0;
        wr_st_en   = 1'b0;
        wr_st      = LN_I;
        wr_tag_en  = 1'b0;
        wr_tag     = acc_tag;
        wr_data_en = 1'b0;
        wr_data    = sel_wdata;

        case (rq_q.fsm)
            RQ_IDLE: begin
                if (cpu_req_valid) begin
                    rq_d.op    = cpu_req_op;
                    rq_d.addr  = cpu_req_addr;
                    rq_d.wdata = cpu_req_wdata;
                    if (plan.need_bus) rq_d.fsm = RQ_WAIT_GNT;
                end
            end
            RQ_WAIT_GNT: begin
                if (!plan.need_bus) begin
                    rq_d.fsm = RQ_IDLE;
                end else if (bus_gnt) begin
                    case (plan.cmd)
                        BC_PUTX: begin
                            wr_st_en = 1'b1;
                            wr_st    = LN_I;
                            if (!plan.victim) begin
                                rq_d.fsm  = RQ_IDLE;
                                rq_d.done = 1'b1;
                            end
                        end
                        BC_UPGR: begin
                            wr_st_en   = 1'b1;
                            wr_st      = LN_M;
                            wr_data_en = 1'b1;
                            rq_d.fsm   = RQ_IDLE;
                            rq_d.done  = 1'b1;
                            rq_d.rdata = sel_wdata;
                        end
                        default: begin
                            wr_st_en  = 1'b1;
                            wr_st     = (plan.cmd == BC_GETS) ? LN_S : LN_M;
                            wr_tag_en = 1'b1;
                            rq_d.fsm  = RQ_WAIT_FILL;
                        end
                    endcase
                end
            end
            RQ_WAIT_FILL: begin
                if (bus_fill_valid) begin
                    wr_data_en = 1'b1;
                    wr_data    = (cpu_op_e'(rq_q.op) == OP_STORE) ? rq_q.wdata : bus_fill_data;
                    rq_d.rdata = wr_data;
                    rq_d.done  = 1'b1;
                    rq_d.fsm   = RQ_IDLE;
                end
            end
            default: rq_d.fsm = RQ_IDLE;
        endcase

        if (local_done) begin
            rq_d.done = 1'b1;
            case (cpu_op_e'(sel_op))
                OP_LOAD:  rq_d.rdata = cur_data;
                OP_STORE: begin
                    wr_data_en = 1'b1;
                    rq_d.rdata = sel_wdata;
                end
                OP_EVICT: begin
                    if (tag_hit) begin
                        wr_st_en = 1'b1;
                        wr_st    = LN_I;
                    end
                end
                default: rq_d.done = 1'b1;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rq_q <= '{fsm: RQ_IDLE, op: '0, addr: '0, wdata: '0, done: 1'b0, rdata: '0};
        end else begin
            rq_q <= rq_d;
        end
    end

    assign cpu_stall = (rq_q.fsm != RQ_IDLE);
    assign cpu_done  = rq_q.done;
    assign cpu_rdata = rq_q.rdata;
    assign bus_req   = (rq_q.fsm == RQ_WAIT_GNT) && plan.need_bus;
    assign bus_cmd   = plan.cmd;
    assign bus_addr  = (plan.cmd == BC_PUTX) ? {tag_i[wr_idx], wr_idx} : sel_addr;
    assign bus_wdata = cur_data;

    AST_BUS_ONLY_STALLED: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req |-> cpu_stall); // R12
    AST_RELEASE_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cpu_stall) |-> cpu_done); // R12
    AST_FILL_NEEDS_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_gnt && (bus_cmd == BC_GETS || bus_cmd == BC_GETX)) |=> cpu_stall && !cpu_done); // R2

endmodule

// File: rtl/msi_snoop_ctrl.sv
module msi_snoop_ctrl
    import msi_pkg::*;
#(
    parameter int AW      = 8,
    parameter int NLINES  = 4,
    parameter int DW      = 16,
    parameter bit UPGR_EN = 1'b1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cpu_req_valid,
    input  logic [1:0]    cpu_req_op,
    input  logic [AW-1:0] cpu_req_addr,
    input  logic [DW-1:0] cpu_req_wdata,
    output logic          cpu_stall,
    output logic          cpu_done,
    output logic [DW-1:0] cpu_rdata,
    output logic          bus_req,
    input  logic          bus_gnt,
    output logic [1:0]    bus_cmd,
    output logic [AW-1:0] bus_addr,
    output logic [DW-1:0] bus_wdata,
    input  logic          bus_fill_valid,
    input  logic [DW-1:0] bus_fill_data,
    input  logic          snp_valid,
    input  logic [1:0]    snp_cmd,
    input  logic [AW-1:0] snp_addr,
    output logic          snp_supply,
    output logic [DW-1:0] snp_data
);

    localparam int IW = $clog2(NLINES);
    localparam int TW = AW - IW;

    logic [NLINES-1:0][1:0]    st_w;
    logic [NLINES-1:0][TW-1:0] tag_w;
    logic [NLINES-1:0][DW-1:0] data_w;

    logic [IW-1:0] wr_idx;
    logic          wr_st_en, wr_tag_en, wr_data_en;
    logic [1:0]    wr_st;
    logic [TW-1:0] wr_tag;
    logic [DW-1:0] wr_data;

    logic          sn_en;
    logic [IW-1:0] sn_idx;
    logic [1:0]    sn_st;

    msi_line_store #(.NLINES(NLINES), .TW(TW), .DW(DW)) i_store (
        .clk, .rst_n,
        .wr_idx, .wr_st_en, .wr_st, .wr_tag_en, .wr_tag, .wr_data_en, .wr_data,
        .sn_en, .sn_idx, .sn_st,
        .st_o(st_w), .tag_o(tag_w), .data_o(data_w)
    );

    msi_snoop_unit #(.AW(AW), .NLINES(NLINES), .DW(DW)) i_snoop (
        .clk, .rst_n, .snp_valid, .snp_cmd, .snp_addr,
        .st_i(st_w), .tag_i(tag_w), .data_i(data_w),
        .upd_en(sn_en), .upd_idx(sn_idx), .upd_st(sn_st),
        .snp_supply, .snp_data
    );

    msi_req_ctrl #(.AW(AW), .NLINES(NLINES), .DW(DW), .UPGR_EN(UPGR_EN)) i_req (
        .clk, .rst_n,
        .cpu_req_valid, .cpu_req_op, .cpu_req_addr, .cpu_req_wdata,
        .cpu_stall, .cpu_done, .cpu_rdata,
        .bus_req, .bus_cmd, .bus_addr, .bus_wdata,
        .bus_gnt, .bus_fill_valid, .bus_fill_data,
        .st_i(st_w), .tag_i(tag_w), .data_i(data_w),
        .wr_idx, .wr_st_en, .wr_st, .wr_tag_en, .wr_tag, .wr_data_en, .wr_data
    );

    // observation helpers for the checks below
    logic [IW-1:0] chk_sidx;
    logic [IW-1:0] chk_bidx;
    logic          chk_smatch;
    assign chk_sidx   = snp_addr[IW-1:0];
    assign chk_bidx   = bus_addr[IW-1:0];
    assign chk_smatch = st_w[chk_sidx] != LN_I && tag_w[chk_sidx] == snp_addr[AW-1:IW];

    AST_ONE_BUS_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
        !(snp_valid && bus_gnt)); // R9
    AST_GETS_DEMOTES_OWNER: assert property (@(posedge clk) disable iff (!rst_n)
        (snp_valid && snp_cmd == BC_GETS && chk_smatch && st_w[chk_sidx] == LN_M)
        |=> snp_supply && st_w[$past(chk_sidx)] == LN_S); // R5
    AST_GETX_INVALIDATES: assert property (@(posedge clk) disable iff (!rst_n)
        (snp_valid && snp_cmd == BC_GETX && chk_smatch) |=> st_w[$past(chk_sidx)] == LN_I); // R6
    AST_SUPPLY_NEEDS_OWNER: assert property (@(posedge clk) disable iff (!rst_n)
        snp_supply |-> $past(snp_valid) && $past(st_w[chk_sidx] == LN_M)); // R5
    AST_PUTX_FROM_OWNER: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_cmd == BC_PUTX) |-> st_w[chk_bidx] == LN_M); // R8
    AST_PUTX_GRANT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_gnt && bus_cmd == BC_PUTX) |=> st_w[$past(chk_bidx)] == LN_I); // R8
    AST_UPGR_FROM_SHARED: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_cmd == BC_UPGR) |-> st_w[chk_bidx] == LN_S); // R4
    AST_UPGR_GRANT_OWNS: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_gnt && bus_cmd == BC_UPGR) |=> st_w[$past(chk_bidx)] == LN_M && cpu_done); // R4

endmodule

// File: tb/test_msi_snoop_ctrl.sv
module test_msi_snoop_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam int AW = 8;
    localparam int DW = 16;
    localparam logic [1:0] LD = 2'd0, ST = 2'd1, EV = 2'd2;
    localparam logic [1:0] GETS = 2'd0, GETX = 2'd1, UPGR = 2'd2, PUTX = 2'd3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cpu_req_valid = 1'b0;
    logic [1:0]    cpu_req_op = '0;
    logic [AW-1:0] cpu_req_addr = '0;
    logic [DW-1:0] cpu_req_wdata = '0;
    logic          cpu_stall, cpu_done;
    logic [DW-1:0] cpu_rdata;
    logic          bus_req;
    logic          bus_gnt = 1'b0;
    logic [1:0]    bus_cmd;
    logic [AW-1:0] bus_addr;
    logic [DW-1:0] bus_wdata;
    logic          bus_fill_valid = 1'b0;
    logic [DW-1:0] bus_fill_data = '0;
    logic          snp_valid = 1'b0;
    logic [1:0]    snp_cmd = '0;
    logic [AW-1:0] snp_addr = '0;
    logic          snp_supply;
    logic [DW-1:0] snp_data;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    msi_snoop_ctrl #(.AW(AW), .NLINES(4), .DW(DW), .UPGR_EN(1'b1)) i_msi_snoop_ctrl (
        .clk, .rst_n, .cpu_req_valid, .cpu_req_op, .cpu_req_addr, .cpu_req_wdata,
        .cpu_stall, .cpu_done, .cpu_rdata, .bus_req, .bus_gnt, .bus_cmd, .bus_addr,
        .bus_wdata, .bus_fill_valid, .bus_fill_data, .snp_valid, .snp_cmd, .snp_addr,
        .snp_supply, .snp_data
    );

    task automatic chk(input string req, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic cpu_issue(input logic [1:0] op, input logic [AW-1:0] a, input logic [DW-1:0] w);
        @(negedge clk);
        cpu_req_valid = 1'b1; cpu_req_op = op; cpu_req_addr = a; cpu_req_wdata = w;
        @(negedge clk);
        cpu_req_valid = 1'b0;
        #1;
    endtask

    task automatic grant();
        bus_gnt = 1'b1;
        @(negedge clk);
        bus_gnt = 1'b0;
        #1;
    endtask

    task automatic fill(input logic [DW-1:0] d);
        bus_fill_valid = 1'b1; bus_fill_data = d;
        @(negedge clk);
        bus_fill_valid = 1'b0;
        #1;
    endtask

    task automatic snoop(input logic [1:0] c, input logic [AW-1:0] a);
        snp_valid = 1'b1; snp_cmd = c; snp_addr = a;
        @(negedge clk);
        snp_valid = 1'b0;
        #1;
    endtask

    // a full read or read-for-ownership miss with its expected bus request
    task automatic miss(input string req, input logic [1:0] op, input logic [AW-1:0] a,
                        input logic [DW-1:0] w, input logic [1:0] cmd, input logic [DW-1:0] fd,
                        input logic [DW-1:0] exp_rd);
        cpu_issue(op, a, w);
        chk(req, "miss bus_req", bus_req, 1);
        chk(req, "miss bus_cmd", bus_cmd, cmd);
        chk(req, "miss bus_addr", bus_addr, a);
        chk(req, "miss stall", cpu_stall, 1);
        grant();
        chk(req, "no done before fill", cpu_done, 0);
        fill(fd);
        chk(req, "fill done", cpu_done, 1);
        chk(req, "fill rdata", cpu_rdata, exp_rd);
        chk(req, "stall released", cpu_stall, 0);
    endtask

    task automatic local_hit(input string req, input logic [1:0] op, input logic [AW-1:0] a,
                             input logic [DW-1:0] w, input logic [DW-1:0] exp_rd);
        cpu_issue(op, a, w);
        chk(req, "hit done", cpu_done, 1);
        chk(req, "hit rdata", cpu_rdata, exp_rd);
        chk(req, "hit no bus_req", bus_req, 0);
        chk(req, "hit no stall", cpu_stall, 0);
    endtask

    task automatic t_reset();
        chk("R1", "stall", cpu_stall, 0);
        chk("R1", "done", cpu_done, 0);
        chk("R1", "bus_req", bus_req, 0);
        chk("R1", "supply", snp_supply, 0);
    endtask

    task automatic t_load_miss();
        miss("R2", LD, 8'h10, 16'h0, GETS, 16'hAAAA, 16'hAAAA);
        local_hit("R2", LD, 8'h10, 16'h0, 16'hAAAA);
    endtask

    task automatic t_store_miss();
        miss("R3", ST, 8'h21, 16'h1234, GETX, 16'h9999, 16'h1234);
        local_hit("R3", LD, 8'h21, 16'h0, 16'h1234);
        local_hit("R3", ST, 8'h21, 16'h5678, 16'h5678);
        local_hit("R3", LD, 8'h21, 16'h0, 16'h5678);
    endtask

    task automatic upgrade(input string req, input logic [AW-1:0] a, input logic [DW-1:0] w);
        cpu_issue(ST, a, w);
        chk(req, "upgrade cmd", bus_cmd, UPGR);
        chk(req, "upgrade req", bus_req, 1);
        chk(req, "upgrade addr", bus_addr, a);
        grant();
        chk(req, "upgrade done after grant", cpu_done, 1);
        chk(req, "upgrade stall released", cpu_stall, 0);
    endtask

    task automatic t_upgrade();
        upgrade("R4", 8'h10, 16'hBEEF);
        local_hit("R4", LD, 8'h10, 16'h0, 16'hBEEF);
    endtask

    task automatic t_snoop_gets();
        snoop(GETS, 8'h10);
        chk("R5", "supply on GETS to M", snp_supply, 1);
        chk("R5", "supplied data", snp_data, 16'hBEEF);
        upgrade("R5", 8'h10, 16'h1111);
    endtask

    task automatic t_snoop_getx();
        snoop(GETX, 8'h10);
        chk("R6", "supply on GETX to M", snp_supply, 1);
        chk("R6", "supplied data", snp_data, 16'h1111);
        miss("R6", LD, 8'h10, 16'h0, GETS, 16'h2222, 16'h2222);
        snoop(GETX, 8'h10);
        chk("R6", "no supply from S", snp_supply, 0);
        miss("R6", LD, 8'h10, 16'h0, GETS, 16'h3333, 16'h3333);
    endtask

    task automatic t_snoop_ignore();
        snoop(GETX, 8'h25);
        chk("R7", "tag mismatch no supply", snp_supply, 0);
        snoop(PUTX, 8'h21);
        chk("R7", "PUTX no supply", snp_supply, 0);
        snoop(GETS, 8'h02);
        chk("R7", "invalid line no supply", snp_supply, 0);
        local_hit("R7", LD, 8'h21, 16'h0, 16'h5678);
        local_hit("R7", ST, 8'h21, 16'h5A5A, 16'h5A5A);
    endtask

    task automatic t_evict();
        cpu_issue(EV, 8'h21, 16'h0);
        chk("R8", "evict M cmd", bus_cmd, PUTX);
        chk("R8", "evict M req", bus_req, 1);
        chk("R8", "evict M addr", bus_addr, 8'h21);
        chk("R8", "evict M data", bus_wdata, 16'h5A5A);
        grant();
        chk("R8", "evict M done", cpu_done, 1);
        miss("R8", LD, 8'h21, 16'h0, GETS, 16'h0F0F, 16'h0F0F);
        cpu_issue(EV, 8'h21, 16'h0);
        chk("R8", "evict S done", cpu_done, 1);
        chk("R8", "evict S no bus", bus_req, 0);
        miss("R8", LD, 8'h21, 16'h0, GETS, 16'h0F0F, 16'h0F0F);
        cpu_issue(EV, 8'h33, 16'h0);
        chk("R8", "evict absent done", cpu_done, 1);
        chk("R8", "evict absent no bus", bus_req, 0);
    endtask

    task automatic t_upgrade_race();
        cpu_issue(ST, 8'h10, 16'h4444);
        chk("R9", "starts as upgrade", bus_cmd, UPGR);
        snoop(GETX, 8'h10);
        chk("R9", "converted to GETX", bus_cmd, GETX);
        chk("R9", "still requesting", bus_req, 1);
        chk("R9", "no supply from S", snp_supply, 0);
        grant();
        chk("R9", "waits for fill", cpu_done, 0);
        fill(16'h7777);
        chk("R9", "done after fill", cpu_done, 1);
        local_hit("R9", LD, 8'h10, 16'h0, 16'h4444);
    endtask

    task automatic t_victim();
        cpu_issue(LD, 8'h14, 16'h0);
        chk("R10", "victim PUTX first", bus_cmd, PUTX);
        chk("R10", "victim addr", bus_addr, 8'h10);
        chk("R10", "victim data", bus_wdata, 16'h4444);
        grant();
        chk("R10", "no done after victim", cpu_done, 0);
        chk("R10", "then GETS", bus_cmd, GETS);
        chk("R10", "demand addr", bus_addr, 8'h14);
        chk("R10", "stall kept", cpu_stall, 1);
        grant();
        fill(16'h5555);
        chk("R10", "done", cpu_done, 1);
        chk("R10", "rdata", cpu_rdata, 16'h5555);
    endtask

    task automatic t_evict_race();
        miss("R11", ST, 8'h22, 16'h6060, GETX, 16'h0000, 16'h6060);
        cpu_issue(EV, 8'h22, 16'h0);
        chk("R11", "evict wants PUTX", bus_cmd, PUTX);
        chk("R12", "stall while waiting", cpu_stall, 1);
        snoop(GETX, 8'h22);
        chk("R11", "supply stolen line", snp_supply, 1);
        chk("R11", "supplied data", snp_data, 16'h6060);
        chk("R11", "PUTX withdrawn", bus_req, 0);
        @(negedge clk);
        #1;
        chk("R11", "evict completes", cpu_done, 1);
        chk("R12", "stall released", cpu_stall, 0);
        miss("R11", LD, 8'h22, 16'h0, GETS, 16'h0101, 16'h0101);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        t_reset();
        t_load_miss();
        t_store_miss();
        t_upgrade();
        t_snoop_gets();
        t_snoop_getx();
        t_snoop_ignore();
        t_evict();
        t_upgrade_race();
        t_victim();
        t_evict_race();
        repeat (2) @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 20000) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

endmodule